// File: doc/BRIEF.md
# Register-File Arithmetic Execution Unit

This block is the execute stage of a small processor. It holds eight general-purpose registers and performs one already-decoded operation per start strobe. An operation reads up to two source registers, or one register and a zero-extended immediate. It writes one or two destination registers and may update a three-bit flags word. A single-cycle done pulse reports that the operation has finished.

Most operations finish in the cycle after the start strobe. Multiply, divide and three-operand remainder use a shared bit-serial engine instead and keep the unit busy for about one cycle per data bit. Every successful division leaves its remainder in an internal latch, and a later one-operand remainder operation copies that latch into a register. Byte and nibble split and combine operations pack and unpack narrow fields. A read-only debug port shows any register so that results can be observed.

Top module: `rfu_exec_unit`

## Requirements
- R1: While reset is held and after it is released, every register reads zero, the flags read zero, and both busy and done are low.
- R2: Opcode values are: 0 nop, 1 load, 2 move, 3 add, 4 sub, 5 mul, 6 div, 7 rem3, 8 remlatch, 9 and, 10 or, 11 xor, 12 shl, 13 shr, 14 not, 15 flagread, 16 split8, 17 split4, 18 comb8, 19 comb4. Every operation other than mul, div and rem3 writes its result and raises done, for exactly one cycle, in the cycle after start is sampled.
- R3: When use_imm is high, the second operand is the 27-bit immediate zero-extended to the data width. Load always takes the immediate. Move copies src_a to dst.
- R4: Add and sub write src_a plus or minus the second operand to dst. The flags word is bit 0 zero, bit 1 carry, bit 2 divide-error. Add sets carry on carry-out. Sub sets carry when the first operand is smaller than the second (borrow).
- R5: Mul writes the low DATA_W bits of the product. For mul, div and rem3, busy is high until done, and done arrives no more than DATA_W+3 cycles after start.
- R6: Div writes the unsigned quotient and stores the remainder in the latch. Remlatch writes the latch to dst.
- R7: Rem3 divides src_a by the second operand, writes only the remainder to dst and also stores it in the latch.
- R8: With a zero divisor, div writes all ones, rem3 writes the dividend, the latch keeps its value, and flag bit 2 is set.
- R9: And, or and xor are bitwise. Shl and shr shift src_a by the low log2(DATA_W) bits of the second operand and fill with zeros. Not inverts register src_a in place.
- R10: Split8 takes bits 15:8 and 7:0 of src_a. Split4 takes bits 7:4 and 3:0. The high part goes to register src_b_idx and the low part to dst, each zero-filled.
- R11: Comb8 writes {src_a[7:0], op2[7:0]} to dst. Comb4 writes {src_a[3:0], op2[3:0]}. Both are zero-filled.
- R12: Flagread writes the flags word, zero-extended, to dst. Arithmetic and logic operations (add, sub, mul, div, rem3, and, or, xor, shl, shr, not) write all three flag bits, with bit 0 set when the result is zero. Load, move, remlatch, flagread, split and comb leave the flags unchanged.
- R13: A start strobe raised while busy is high is ignored and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation presented on the operand inputs |
| op | input | 5 | Decoded operation code |
| src_a_idx | input | 3 | First source register (also target of not) |
| src_b_idx | input | 3 | Second source register; high-part target of split |
| dst_idx | input | 3 | Destination register |
| use_imm | input | 1 | Use the immediate as the second operand |
| imm | input | 27 | Immediate value |
| dbg_idx | input | 3 | Register selected for the debug read |
| dbg_data | output | 32 | Current value of the selected register |
| flags | output | 3 | {divide-error, carry, zero} |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 32-bit data, eight registers and a 27-bit immediate. With these values the full 32-step serial multiply and divide run, including an all-ones by all-ones product whose kept low bits are 1 and a multiply by the largest immediate. Zero-filling of split and combine results is visible across the full upper 16 or 24 bits. The shift test uses an amount of 36, which only behaves correctly if the unit masks the amount to its low five bits.

// File: rtl/rfu_pkg.sv
package rfu_pkg;

    typedef enum logic [4:0] {
        OP_NOP    = 5'd0,
        OP_LOAD   = 5'd1,
        OP_MOV    = 5'd2,
        OP_ADD    = 5'd3,
        OP_SUB    = 5'd4,
        OP_MUL    = 5'd5,
        OP_DIV    = 5'd6,
        OP_REM3   = 5'd7,
        OP_REML   = 5'd8,
        OP_AND    = 5'd9,
        OP_OR     = 5'd10,
        OP_XOR    = 5'd11,
        OP_SHL    = 5'd12,
        OP_SHR    = 5'd13,
        OP_NOT    = 5'd14,
        OP_FLAGRD = 5'd15,
        OP_SPL8   = 5'd16,
        OP_SPL4   = 5'd17,
        OP_CMB8   = 5'd18,
        OP_CMB4   = 5'd19
    } op_e;

    typedef struct packed {
        logic err;
        logic carry;
        logic zero;
    } flags_t;

    function automatic logic is_serial(op_e o);
        return (o == OP_MUL) || (o == OP_DIV) || (o == OP_REM3);
    endfunction

    function automatic logic fast_sets_flags(op_e o);
        case (o)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
            OP_SHL, OP_SHR, OP_NOT: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rfu_regfile.sv
module rfu_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [IDX_W-1:0]  rdbg_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] rdbg_data,
    input  logic              we0,
    input  logic [IDX_W-1:0]  wi0,
    input  logic [DATA_W-1:0] wd0,
    input  logic              we1,
    input  logic [IDX_W-1:0]  wi1,
    input  logic [DATA_W-1:0] wd1
);
    logic [DATA_W-1:0] cells [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        logic [DATA_W-1:0] q;
        // port 0 wins when both ports target the same register
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we0 && wi0 == IDX_W'(g))
                q <= wd0;
            else if (we1 && wi1 == IDX_W'(g))
                q <= wd1;
        end
        assign cells[g] = q;
    end

    assign ra_data   = cells[ra_idx];
    assign rb_data   = cells[rb_idx];
    assign rdbg_data = cells[rdbg_idx];
endmodule

// File: rtl/rfu_alu.sv
module rfu_alu
    import rfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic [DATA_W-1:0] res_hi,
    output logic              carry
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W:0]   wide_sum;
    logic [SH_W-1:0]   sh_amt;

    assign wide_sum = {1'b0, a} + {1'b0, b};
    assign sh_amt   = b[SH_W-1:0];

    always_comb begin
        res    = '0;
        res_hi = '0;
        carry  = 1'b0;
        case (op)
            OP_LOAD: res = b;
            OP_MOV:  res = a;
            OP_ADD: begin
                res   = wide_sum[DATA_W-1:0];
                carry = wide_sum[DATA_W];
            end
            OP_SUB: begin
                res   = a - b;
                carry = (a < b);
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SHL:  res = a << sh_amt;
            OP_SHR:  res = a >> sh_amt;
            OP_NOT:  res = ~a;
            OP_SPL8: begin
                res_hi = DATA_W'(a[15:8]);
                res    = DATA_W'(a[7:0]);
            end
            OP_SPL4: begin
                res_hi = DATA_W'(a[7:4]);
                res    = DATA_W'(a[3:0]);
            end
            OP_CMB8: res = DATA_W'({a[7:0], b[7:0]});
            OP_CMB4: res = DATA_W'({a[3:0], b[3:0]});
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/rfu_serial_md.sv
module rfu_serial_md #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              div_mode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              fin,
    output logic [DATA_W-1:0] quot_prod,
    output logic [DATA_W-1:0] remainder
);
    localparam int CNT_W = $clog2(DATA_W);

    logic              run;
    logic              mode_div;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] x, y, acc;
    logic [DATA_W-1:0] x_n, y_n, acc_n;
    logic [DATA_W:0]   shifted, trial;
    logic              fits;

    // one restoring-division or shift-add step per cycle
    always_comb begin
        shifted = {acc, x[DATA_W-1]};
        trial   = shifted - {1'b0, y};
        fits    = ~trial[DATA_W];
        if (mode_div) begin
            acc_n = fits ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
            x_n   = {x[DATA_W-2:0], fits};
            y_n   = y;
        end else begin
            acc_n = x[0] ? acc + y : acc;
            x_n   = x >> 1;
            y_n   = y << 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            fin      <= 1'b0;
            mode_div <= 1'b0;
            cnt      <= '0;
            x        <= '0;
            y        <= '0;
            acc      <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                run      <= 1'b1;
                mode_div <= div_mode;
                cnt      <= '0;
                x        <= opa;
                y        <= opb;
                acc      <= '0;
            end else if (run) begin
                x   <= x_n;
                y   <= y_n;
                acc <= acc_n;
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(DATA_W - 1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign quot_prod = mode_div ? x : acc;
    assign remainder = acc;

    assert_fin_single_R5: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin);

    assert_no_restart_R13: assert property (@(posedge clk) disable iff (rst)
        run |-> !go);
endmodule

// File: rtl/rfu_exec_unit.sv
module rfu_exec_unit
    import rfu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    parameter int IMM_W  = 27,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [4:0]        op,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  dbg_idx,
    output logic [DATA_W-1:0] dbg_data,
    output logic [2:0]        flags,
    output logic              busy,
    output logic              done
);
    op_e               op_c;
    logic [DATA_W-1:0] ra, rb, opnd2, imm_ext;
    logic [DATA_W-1:0] alu_res, alu_hi;
    logic              alu_carry;
    logic              accept, fast_go, seq_go;
    logic              seq_fin;
    logic [DATA_W-1:0] seq_q, seq_r, seq_res;
    logic              we0, we1;
    logic [IDX_W-1:0]  wi0, wi1;
    logic [DATA_W-1:0] wd0, wd1;

    flags_t            flags_q;
    logic [DATA_W-1:0] rem_q;
    logic              busy_q, done_q;
    op_e               pend_op;
    logic [IDX_W-1:0]  pend_dst;
    logic              pend_zero;

    assign op_c    = op_e'(op);
    assign imm_ext = DATA_W'(imm);
    assign opnd2   = (use_imm || op_c == OP_LOAD) ? imm_ext : rb;
    assign accept  = start && !busy_q;
    assign seq_go  = accept && is_serial(op_c);
    assign fast_go = accept && !is_serial(op_c);
    assign seq_res = (pend_op == OP_REM3) ? seq_r : seq_q;

    rfu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .ra_idx(src_a_idx), .rb_idx(src_b_idx), .rdbg_idx(dbg_idx),
        .ra_data(ra), .rb_data(rb), .rdbg_data(dbg_data),
        .we0(we0), .wi0(wi0), .wd0(wd0),
        .we1(we1), .wi1(wi1), .wd1(wd1)
    );

    rfu_alu #(.DATA_W(DATA_W)) u_alu (
        .op(op_c), .a(ra), .b(opnd2),
        .res(alu_res), .res_hi(alu_hi), .carry(alu_carry)
    );

    rfu_serial_md #(.DATA_W(DATA_W)) u_md (
        .clk(clk), .rst(rst), .go(seq_go),
        .div_mode(op_c != OP_MUL),
        .opa(ra), .opb(opnd2),
        .fin(seq_fin), .quot_prod(seq_q), .remainder(seq_r)
    );

    // write-port steering
    always_comb begin
        we0 = 1'b0;
        wi0 = dst_idx;
        wd0 = alu_res;
        we1 = 1'b0;
        wi1 = src_b_idx;
        wd1 = alu_hi;
        if (busy_q && seq_fin) begin
            we0 = 1'b1;
            wi0 = pend_dst;
            wd0 = seq_res;
        end else if (fast_go) begin
            case (op_c)
                OP_LOAD, OP_MOV, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
                OP_SHL, OP_SHR, OP_CMB8, OP_CMB4: we0 = 1'b1;
                OP_NOT: begin
                    we0 = 1'b1;
                    wi0 = src_a_idx;
                end
                OP_REML: begin
                    we0 = 1'b1;
                    wd0 = rem_q;
                end
                OP_FLAGRD: begin
                    we0 = 1'b1;
                    wd0 = DATA_W'(flags_q);
                end
                OP_SPL8, OP_SPL4: begin
                    we0 = 1'b1;
                    we1 = 1'b1;
                end
                default: we0 = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= '0;
            rem_q     <= '0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            pend_op   <= OP_NOP;
            pend_dst  <= '0;
            pend_zero <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q && seq_fin) begin
                busy_q        <= 1'b0;
                done_q        <= 1'b1;
                flags_q.zero  <= (seq_res == '0);
                flags_q.carry <= 1'b0;
                flags_q.err   <= pend_zero;
                if (pend_op != OP_MUL && !pend_zero)
                    rem_q <= seq_r;
            end else if (seq_go) begin
                busy_q    <= 1'b1;
                pend_op   <= op_c;
                pend_dst  <= dst_idx;
                pend_zero <= (op_c != OP_MUL) && (opnd2 == '0);
            end else if (fast_go) begin
                done_q <= 1'b1;
                if (fast_sets_flags(op_c)) begin
                    flags_q.zero  <= (alu_res == '0);
                    flags_q.carry <= alu_carry;
                    flags_q.err   <= 1'b0;
                end
            end
        end
    end

    assign flags = flags_q;
    assign busy  = busy_q;
    assign done  = done_q;

    assert_fast_done_R2: assert property (@(posedge clk) disable iff (rst)
        fast_go |=> done && !busy);

    assert_serial_done_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && seq_fin) |=> done && !busy);

    assert_busy_held_R13: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !seq_fin) |=> busy_q && !done);

    assert_div0_latch_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && seq_fin && pend_zero) |=> $stable(rem_q) && flags[2]);
endmodule

// File: tb/test_rfu_exec_unit.sv
`timescale 1ns/1ps
module test_rfu_exec_unit;
    localparam int DATA_W = 32;
    localparam int LIMIT  = DATA_W + 3;
    localparam int NV     = 29;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [4:0]  op;
    logic [2:0]  src_a_idx, src_b_idx, dst_idx, dbg_idx;
    logic        use_imm;
    logic [26:0] imm;
    logic [31:0] dbg_data;
    logic [2:0]  flags;
    logic        busy, done;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    rfu_exec_unit i_rfu_exec_unit (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .use_imm(use_imm), .imm(imm), .dbg_idx(dbg_idx),
        .dbg_data(dbg_data), .flags(flags), .busy(busy), .done(done)
    );

    // {op, a, b, dst, use_imm, imm, check_reg, expected, expected_flags}
    localparam logic [79:0] VEC [NV] = '{
        {5'd1, 3'd0,3'd0,3'd0,1'b1,27'd100,    3'd0,32'd100,       3'b000}, // R2 R3
        {5'd1, 3'd0,3'd0,3'd1,1'b1,27'd7,      3'd1,32'd7,         3'b000}, // R3
        {5'd3, 3'd0,3'd1,3'd2,1'b0,27'd0,      3'd2,32'd107,       3'b000}, // R4
        {5'd4, 3'd1,3'd0,3'd3,1'b0,27'd0,      3'd3,32'hFFFFFFA3,  3'b010}, // R4 borrow
        {5'd3, 3'd3,3'd0,3'd4,1'b1,27'd93,     3'd4,32'd0,         3'b011}, // R4 carry+zero
        {5'd5, 3'd0,3'd1,3'd5,1'b0,27'd0,      3'd5,32'd700,       3'b000}, // R5
        {5'd6, 3'd0,3'd0,3'd6,1'b1,27'd7,      3'd6,32'd14,        3'b000}, // R6
        {5'd8, 3'd0,3'd0,3'd7,1'b0,27'd0,      3'd7,32'd2,         3'b000}, // R6
        {5'd7, 3'd5,3'd2,3'd7,1'b0,27'd0,      3'd7,32'd58,        3'b000}, // R7
        {5'd6, 3'd0,3'd0,3'd6,1'b1,27'd0,      3'd6,32'hFFFFFFFF,  3'b100}, // R8
        {5'd8, 3'd0,3'd0,3'd7,1'b0,27'd0,      3'd7,32'd58,        3'b100}, // R8 latch kept
        {5'd15,3'd0,3'd0,3'd4,1'b0,27'd0,      3'd4,32'd4,         3'b100}, // R12
        {5'd1, 3'd0,3'd0,3'd0,1'b1,27'hABCD,   3'd0,32'hABCD,      3'b100}, // R12 flags kept
        {5'd16,3'd0,3'd1,3'd2,1'b0,27'd0,      3'd1,32'hAB,        3'b100}, // R10
        {5'd2, 3'd2,3'd0,3'd3,1'b0,27'd0,      3'd3,32'hCD,        3'b100}, // R10 R3
        {5'd17,3'd0,3'd1,3'd2,1'b0,27'd0,      3'd1,32'hC,         3'b100}, // R10
        {5'd18,3'd1,3'd2,3'd3,1'b0,27'd0,      3'd3,32'h0C0D,      3'b100}, // R11
        {5'd19,3'd2,3'd0,3'd3,1'b1,27'd7,      3'd3,32'hD7,        3'b100}, // R11
        {5'd9, 3'd0,3'd0,3'd4,1'b1,27'hFF0,    3'd4,32'hBC0,       3'b000}, // R9
        {5'd10,3'd4,3'd0,3'd4,1'b1,27'hF,      3'd4,32'hBCF,       3'b000}, // R9
        {5'd11,3'd4,3'd4,3'd5,1'b0,27'd0,      3'd5,32'd0,         3'b001}, // R9 R12
        {5'd12,3'd1,3'd0,3'd1,1'b1,27'd4,      3'd1,32'hC0,        3'b000}, // R9
        {5'd13,3'd0,3'd0,3'd2,1'b1,27'd36,     3'd2,32'hABC,       3'b000}, // R9
        {5'd14,3'd5,3'd0,3'd0,1'b0,27'd0,      3'd5,32'hFFFFFFFF,  3'b000}, // R9
        {5'd5, 3'd5,3'd5,3'd6,1'b0,27'd0,      3'd6,32'd1,         3'b000}, // R5
        {5'd4, 3'd1,3'd1,3'd6,1'b0,27'd0,      3'd6,32'd0,         3'b001}, // R4
        {5'd7, 3'd0,3'd0,3'd7,1'b1,27'd0,      3'd7,32'hABCD,      3'b100}, // R8
        {5'd8, 3'd0,3'd0,3'd6,1'b0,27'd0,      3'd6,32'd58,        3'b100}, // R8 R6
        {5'd5, 3'd0,3'd0,3'd7,1'b1,27'h7FFFFFF,3'd7,32'h67FF5433,  3'b000}  // R5 R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] o, input logic [2:0] a, input logic [2:0] b,
                         input logic [2:0] d, input logic ui, input logic [26:0] iv,
                         output int lat);
        @(negedge clk);
        op = o; src_a_idx = a; src_b_idx = b; dst_idx = d; use_imm = ui; imm = iv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < LIMIT) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R5 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        int done_cnt;
        logic serial;
        rst = 1'b1; start = 1'b0; op = '0; src_a_idx = '0; src_b_idx = '0;
        dst_idx = '0; use_imm = 1'b0; imm = '0; dbg_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int r = 0; r < 8; r++) begin
            dbg_idx = 3'(r);
            #0.1;
            check("R1 reg", dbg_data, 32'd0);
        end
        check("R1 flags", {29'd0, flags}, 32'd0);
        check("R1 busy/done", {30'd0, busy, done}, 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][79:75], VEC[i][74:72], VEC[i][71:69], VEC[i][68:66],
                  VEC[i][65], VEC[i][64:38], lat);
            serial = (VEC[i][79:75] == 5'd5) || (VEC[i][79:75] == 5'd6) ||
                     (VEC[i][79:75] == 5'd7);
            check("R5 done seen", {31'd0, done}, 32'd1);
            if (!serial)
                check("R2 one-cycle latency", 32'(lat), 32'd1);
            dbg_idx = VEC[i][37:35];
            #0.1;
            check($sformatf("vector %0d result", i), dbg_data, VEC[i][34:3]);
            check($sformatf("vector %0d flags R4 R12", i), {29'd0, flags}, {29'd0, VEC[i][2:0]});
        end

        // R13: start while busy ignored
        issue(5'd1, 3'd0, 3'd0, 3'd0, 1'b1, 27'd5, lat);
        @(negedge clk);
        op = 5'd5; src_a_idx = 3'd0; src_b_idx = 3'd0; dst_idx = 3'd1;
        use_imm = 1'b1; imm = 27'd3; start = 1'b1;
        @(negedge clk);
        check("R5 busy during mul", {31'd0, busy}, 32'd1);
        op = 5'd1; dst_idx = 3'd0; imm = 27'd9;
        @(negedge clk);
        start = 1'b0;
        done_cnt = 0;
        for (int c = 0; c < LIMIT + 4; c++) begin
            if (done) done_cnt++;
            @(negedge clk);
        end
        check("R13 one completion", 32'(done_cnt), 32'd1);
        dbg_idx = 3'd0;
        #0.1;
        check("R13 target unchanged", dbg_data, 32'd5);
        dbg_idx = 3'd1;
        #0.1;
        check("R13 mul result", dbg_data, 32'd15);

        // R1: reset clears state again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        dbg_idx = 3'd1;
        #0.1;
        check("R1 reg after reset", dbg_data, 32'd0);
        check("R1 flags after reset", {29'd0, flags}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule